// File: doc/BRIEF.md
# Inter-Processor Trunk Port

This block is one processor's end of a point-to-point control link to its peer processors. Each link is called a trunk, and a processor may have up to six of them. The CPU drives the block through a single command port with three commands.

- **Write command.** Loads an 8-bit status byte that is presented unchanged on every trunk. The byte holds until the next write. In the same cycle the command fires a one-cycle signal pulse on each trunk chosen by a select mask.
- **Read command.** Names one trunk and returns the 8-bit byte its peer presents. A trunk whose read-permit line is low reads as zero. An index that names no installed trunk reads as zero and flags an error.
- **Clear command.** Clears interrupt flags. Incoming peer signals are synchronized and edge-detected, and each edge sets a sticky interrupt flag for its trunk. The clear command releases flags one for one by mask.

The block also drives a power-warning output. The output drops when a power failure is reported. It then stays low for a fixed grace window of `GRACE_CYCLES` clocks, and a restore report is accepted only after that window has ended. No parity is generated on the outgoing byte, and none is checked on the incoming bytes.

The command encoding is `cmdOp`: 1 = write, 2 = read, 3 = clear, 0 = idle. A command is taken on a clock edge where `cmdValid` is high. Trunk n (n = 1 to 6) uses mask bit n-1, byte lane `staticIn[(n-1)*8 +: 8]`, permit bit n-1, signal bit n-1 and flag bit n-1. `NUM_TRUNKS` sets how many trunks are installed.

Top module: `xpc_trunk_port`

## Requirements
- R1: `staticOut` is 0 after reset, takes `cmdData` on the edge that accepts a write command, and holds that value until the next write.
- R2: For the one cycle after a write command, `sigOut[n-1]` is high for each installed trunk n whose `cmdMask[n-1]` is 1. Otherwise `sigOut` is all zero.
- R3: Mask bits, signal inputs and flags of trunks above `NUM_TRUNKS` have no effect. Their `sigOut` and `intFlags` bits stay 0.
- R4: In the cycle after a read command with `cmdIdx` = n (1 to `NUM_TRUNKS`), `rdValid` is 1, `rdErr` is 0 and `rdData` equals byte lane n of `staticIn`.
- R5: A read of trunk n while `rdPermit[n-1]` is 0 returns `rdData` = 0 with `rdErr` = 0.
- R6: A read with `cmdIdx` equal to 0 or above `NUM_TRUNKS` returns `rdData` = 0, with `rdValid` and `rdErr` high for exactly one cycle.
- R7: A rising edge on `extSigIn[n-1]` of an installed trunk sets `intFlags[n-1]` on the third clock edge after the input rises. A level that stays high does not set the flag again.
- R8: A clear command clears each flag whose `cmdMask` bit is 1 on the next edge and leaves the other flags unchanged.
- R9: `pfWarn` is 1 after reset and falls on the edge where `pwrFailDetect` is seen high.
- R10: After `pfWarn` falls, `graceDone` rises exactly `GRACE_CYCLES` edges later. Until then `pwrRestored` is ignored, and a repeated failure report does not restart the window.
- R11: While `graceDone` is 1, `pwrRestored` brings `pfWarn` back to 1 and `graceDone` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 1 write, 2 read, 3 clear flags |
| cmdData | input | 8 | Byte for a write command |
| cmdMask | input | 6 | Trunk select for write and clear; bit n-1 is trunk n |
| cmdIdx | input | 3 | Trunk number for a read |
| staticIn | input | 48 | Peer bytes, trunk n at bits (n-1)*8 +: 8 |
| rdPermit | input | 6 | Per-trunk read permit; low forces zero |
| extSigIn | input | 6 | Per-trunk incoming peer signal (asynchronous) |
| pwrFailDetect | input | 1 | Power failure report |
| pwrRestored | input | 1 | Power restored report |
| staticOut | output | 8 | Common outgoing byte |
| sigOut | output | 6 | Per-trunk one-cycle signal pulse |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | Read result valid, one cycle |
| rdErr | output | 1 | Bad trunk index, one cycle |
| intFlags | output | 6 | Sticky per-trunk interrupt flags |
| pfWarn | output | 1 | Power warning, high when normal |
| graceDone | output | 1 | Grace window expired |

## Verification
The hardest case to reach is a restore report, or a second failure report, that arrives in the middle of the grace window. Both must be ignored, and the window must still end on its exact edge. The bench shortens the window through the parameter. It then pulses both reports partway through and counts edges to the precise cycle where `graceDone` must rise. The uninstalled-trunk paths cannot be reached at the full trunk count, so the bench builds the block with five trunks. It then drives trunk six's mask bit, signal input and read index.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  localparam int MAX_TRUNKS = 6;
  localparam int BYTE_W     = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_CLEAR = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic loadOut;
    logic pulse;
    logic readOk;
    logic readBad;
    logic clearFlags;
  } strobe_t;
endpackage

// File: rtl/xpc_ctrl.sv
module xpc_ctrl
  import xpc_pkg::*;
#(
  parameter int NUM_TRUNKS   = 6,
  parameter int GRACE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [2:0] cmdIdx,
  input  logic       pwrFailDetect,
  input  logic       pwrRestored,
  output strobe_t    stb,
  output logic       pfWarn,
  output logic       graceDone
);
  localparam int CNT_W = $clog2(GRACE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRACE_CYCLES - 1);

  typedef enum logic [1:0] {PW_NORMAL, PW_GRACE, PW_DONE} pw_state_e;

  pw_state_e pwState;
  logic [CNT_W-1:0] graceCnt;
  logic idxOk;

  assign idxOk = (cmdIdx != 3'd0) && (cmdIdx <= 3'(NUM_TRUNKS));

  always_comb begin
    stb = '0;
    if (cmdValid) begin
      unique case (cmd_op_e'(cmdOp))
        OP_WRITE: begin stb.loadOut = 1'b1; stb.pulse = 1'b1; end
        OP_READ:  begin stb.readOk = idxOk; stb.readBad = !idxOk; end
        OP_CLEAR: stb.clearFlags = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwState  <= PW_NORMAL;
      graceCnt <= '0;
    end else begin
      unique case (pwState)
        PW_NORMAL: if (pwrFailDetect) begin
          pwState  <= PW_GRACE;
          graceCnt <= '0;
        end
        PW_GRACE: begin
          if (graceCnt == LAST) pwState <= PW_DONE;
          else graceCnt <= graceCnt + 1'b1;
        end
        PW_DONE: if (pwrRestored) pwState <= PW_NORMAL;
        default: pwState <= PW_NORMAL;
      endcase
    end
  end

  assign pfWarn    = (pwState == PW_NORMAL);
  assign graceDone = (pwState == PW_DONE);
endmodule

// File: rtl/xpc_datapath.sv
module xpc_datapath
  import xpc_pkg::*;
#(
  parameter int NUM_TRUNKS = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [BYTE_W-1:0]            cmdData,
  input  logic [MAX_TRUNKS-1:0]        cmdMask,
  input  logic [2:0]                   cmdIdx,
  input  logic [MAX_TRUNKS*BYTE_W-1:0] staticIn,
  input  logic [MAX_TRUNKS-1:0]        rdPermit,
  input  logic [MAX_TRUNKS-1:0]        extSigIn,
  output logic [BYTE_W-1:0]            staticOut,
  output logic [MAX_TRUNKS-1:0]        sigOut,
  output logic [BYTE_W-1:0]            rdData,
  output logic                         rdValid,
  output logic                         rdErr,
  output logic [MAX_TRUNKS-1:0]        intFlags
);
  localparam logic [MAX_TRUNKS-1:0] INSTALLED = MAX_TRUNKS'((1 << NUM_TRUNKS) - 1);

  logic [BYTE_W-1:0] lane [MAX_TRUNKS];
  logic [BYTE_W-1:0] selByte;
  logic [MAX_TRUNKS-1:0] syncA, syncB, syncC, riseEv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staticOut <= '0;
      sigOut    <= '0;
    end else begin
      if (stb.loadOut) staticOut <= cmdData;
      sigOut <= stb.pulse ? (cmdMask & INSTALLED) : '0;
    end
  end

  for (genvar i = 0; i < MAX_TRUNKS; i++) begin : g_trunk
    if (i < NUM_TRUNKS) begin : g_on
      assign lane[i] = rdPermit[i] ? staticIn[i*BYTE_W +: BYTE_W] : '0;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA[i] <= 1'b0; syncB[i] <= 1'b0; syncC[i] <= 1'b0;
        end else begin
          syncA[i] <= extSigIn[i];
          syncB[i] <= syncA[i];
          syncC[i] <= syncB[i];
        end
      end
      assign riseEv[i] = syncB[i] & ~syncC[i];
    end else begin : g_off
      assign lane[i]   = '0;
      assign syncA[i]  = 1'b0;
      assign syncB[i]  = 1'b0;
      assign syncC[i]  = 1'b0;
      assign riseEv[i] = 1'b0;
    end
  end

  always_comb begin
    selByte = '0;
    for (int i = 0; i < MAX_TRUNKS; i++)
      if (cmdIdx == 3'(i + 1)) selByte = lane[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      rdErr    <= 1'b0;
      intFlags <= '0;
    end else begin
      rdValid <= stb.readOk | stb.readBad;
      rdErr   <= stb.readBad;
      if (stb.readOk)  rdData <= selByte;
      if (stb.readBad) rdData <= '0;
      intFlags <= ((intFlags & ~(stb.clearFlags ? cmdMask : '0)) | riseEv) & INSTALLED;
    end
  end
endmodule

// File: rtl/xpc_trunk_port.sv
module xpc_trunk_port
  import xpc_pkg::*;
#(
  parameter int NUM_TRUNKS   = 6,
  parameter int GRACE_CYCLES = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [7:0]  cmdData,
  input  logic [5:0]  cmdMask,
  input  logic [2:0]  cmdIdx,
  input  logic [47:0] staticIn,
  input  logic [5:0]  rdPermit,
  input  logic [5:0]  extSigIn,
  input  logic        pwrFailDetect,
  input  logic        pwrRestored,
  output logic [7:0]  staticOut,
  output logic [5:0]  sigOut,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        rdErr,
  output logic [5:0]  intFlags,
  output logic        pfWarn,
  output logic        graceDone
);
  strobe_t stb;

  xpc_ctrl #(.NUM_TRUNKS(NUM_TRUNKS), .GRACE_CYCLES(GRACE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .pwrFailDetect(pwrFailDetect), .pwrRestored(pwrRestored),
    .stb(stb), .pfWarn(pfWarn), .graceDone(graceDone)
  );

  xpc_datapath #(.NUM_TRUNKS(NUM_TRUNKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdData(cmdData), .cmdMask(cmdMask),
    .cmdIdx(cmdIdx), .staticIn(staticIn), .rdPermit(rdPermit), .extSigIn(extSigIn),
    .staticOut(staticOut), .sigOut(sigOut), .rdData(rdData), .rdValid(rdValid),
    .rdErr(rdErr), .intFlags(intFlags)
  );
endmodule

// File: rtl/xpc_trunk_chk.sv
module xpc_trunk_chk #(
  parameter int NUM_TRUNKS = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [7:0] staticOut,
  input logic [5:0] sigOut,
  input logic [7:0] rdData,
  input logic       rdErr,
  input logic [5:0] intFlags,
  input logic       pfWarn,
  input logic       graceDone
);
  localparam logic [5:0] UNUSED = ~6'((1 << NUM_TRUNKS) - 1);

  // R1
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !($past(cmdValid) && $past(cmdOp) == 2'd1) |-> $stable(staticOut));

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sigOut != 6'd0) |-> ($past(cmdValid) && $past(cmdOp) == 2'd1));

  // R3
  unused_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sigOut & UNUSED) == 6'd0) && ((intFlags & UNUSED) == 6'd0));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == 8'd0));

  // R11
  warn_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfWarn) |-> $past(graceDone));

  // R10
  done_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    graceDone |-> !pfWarn);
endmodule

bind xpc_trunk_port xpc_trunk_chk #(.NUM_TRUNKS(NUM_TRUNKS)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .staticOut(staticOut), .sigOut(sigOut), .rdData(rdData), .rdErr(rdErr),
  .intFlags(intFlags), .pfWarn(pfWarn), .graceDone(graceDone)
);

// File: tb/sim_xpc_trunk_port.sv
`timescale 1ns/1ps
module sim_xpc_trunk_port;
  localparam int NT = 5;
  localparam int GC = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdData = 8'd0;
  logic [5:0] cmdMask = 6'd0;
  logic [2:0] cmdIdx = 3'd0;
  logic [47:0] staticIn = 48'd0;
  logic [5:0] rdPermit = 6'h3F;
  logic [5:0] extSigIn = 6'd0;
  logic pwrFailDetect = 1'b0;
  logic pwrRestored = 1'b0;
  logic [7:0] staticOut, rdData;
  logic [5:0] sigOut, intFlags;
  logic rdValid, rdErr, pfWarn, graceDone;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  xpc_trunk_port #(.NUM_TRUNKS(NT), .GRACE_CYCLES(GC)) u0 (.*);

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [7:0] d, logic [5:0] m, logic [2:0] ix);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d; cmdMask = m; cmdIdx = ix;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
  endtask

  task automatic t_reset;
    check("R1 reset staticOut", 48'(staticOut), 48'd0);
    check("R2 reset sigOut", 48'(sigOut), 48'd0);
    check("R9 reset pfWarn", 48'(pfWarn), 48'd1);
    check("R8 reset flags", 48'(intFlags), 48'd0);
  endtask

  task automatic t_write;
    issue(2'd1, 8'hA5, 6'b000101, 3'd0);
    check("R1 load", 48'(staticOut), 48'hA5);
    check("R2 pulse", 48'(sigOut), 48'b000101);
    @(negedge clk);
    check("R2 pulse ends", 48'(sigOut), 48'd0);
    check("R1 hold", 48'(staticOut), 48'hA5);
    issue(2'd2, 8'h00, 6'd0, 3'd1);
    check("R1 hold over read", 48'(staticOut), 48'hA5);
    issue(2'd1, 8'h3C, 6'b111111, 3'd0);
    check("R1 reload", 48'(staticOut), 48'h3C);
    check("R3 trunk6 ignored", 48'(sigOut), 48'b011111);
  endtask

  task automatic t_read;
    staticIn = 48'h6655_4433_2211;
    for (int n = 1; n <= NT; n++) begin
      issue(2'd2, 8'h00, 6'd0, 3'(n));
      check("R4 data", 48'(rdData), 48'((48'h6655_4433_2211 >> ((n - 1) * 8)) & 48'hFF));
      check("R4 valid", 48'({rdValid, rdErr}), 48'b10);
    end
    rdPermit = 6'b111011;
    issue(2'd2, 8'h00, 6'd0, 3'd3);
    check("R5 inhibit", 48'({rdValid, rdErr, rdData}), 48'h200);
    rdPermit = 6'h3F;
  endtask

  task automatic t_badidx;
    issue(2'd2, 8'h00, 6'd0, 3'd6);
    check("R6 idx6", 48'({rdValid, rdErr, rdData}), 48'h300);
    @(negedge clk);
    check("R6 one cycle", 48'({rdValid, rdErr}), 48'd0);
    issue(2'd2, 8'h00, 6'd0, 3'd0);
    check("R6 idx0", 48'({rdValid, rdErr, rdData}), 48'h300);
  endtask

  task automatic t_flags;
    @(negedge clk);
    extSigIn = 6'b100110;
    @(negedge clk);
    @(negedge clk);
    check("R7 not yet", 48'(intFlags), 48'd0);
    @(negedge clk);
    check("R7 set", 48'(intFlags), 48'b000110);
    issue(2'd3, 8'h00, 6'b000010, 3'd0);
    check("R8 partial clear", 48'(intFlags), 48'b000100);
    repeat (5) @(negedge clk);
    check("R7 level no reset", 48'(intFlags), 48'b000100);
    check("R3 trunk6 flag", 48'(intFlags[5]), 48'd0);
    issue(2'd3, 8'h00, 6'b111111, 3'd0);
    check("R8 clear all", 48'(intFlags), 48'd0);
    extSigIn = 6'd0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_power;
    @(negedge clk);
    pwrFailDetect = 1'b1;
    @(negedge clk);
    pwrFailDetect = 1'b0;
    check("R9 fall", 48'(pfWarn), 48'd0);
    repeat (5) @(negedge clk);
    pwrRestored = 1'b1; pwrFailDetect = 1'b1;
    @(negedge clk);
    pwrRestored = 1'b0; pwrFailDetect = 1'b0;
    check("R10 restore ignored", 48'({pfWarn, graceDone}), 48'd0);
    repeat (GC - 7) @(negedge clk);
    check("R10 not done", 48'(graceDone), 48'd0);
    @(negedge clk);
    check("R10 done", 48'({pfWarn, graceDone}), 48'b01);
    pwrRestored = 1'b1;
    @(negedge clk);
    pwrRestored = 1'b0;
    check("R11 restored", 48'({pfWarn, graceDone}), 48'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_badidx();
    t_flags();
    t_power();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule